// File: doc/BRIEF.md
# Asynchronous-to-Synchronous Transmit Rate Adapter

This block takes a start-stop serial line that runs on its own timing and re-times it onto a synchronous bit clock. A sample enable at sixteen times the bit rate drives a character receiver. The receiver checks each start bit at mid-bit and stores each complete character in a two-entry buffer. The transmit side sends one bit per synchronous bit enable.

A small rate mismatch between the two sides is absorbed at the character boundaries. When the line runs slow, extra mark bits are placed between characters. When it runs fast, a stop bit is occasionally dropped, at a limited frequency. A long run of space is treated as a break. The break is stretched to a minimum length and followed by a guard interval of mark. Two further modes are available. In boosted-clock mode nothing is deleted and breaks are not stretched. In bypass mode the output is the input wire.

Top module: `astx_rate_adapter`

## Requirements
- R1: The total character length M (start + data/parity + stop) is chosen by `len_sel`: 2'b10 gives 8, 2'b00 gives 9, 2'b11 gives 10, 2'b01 gives 11.
- R2: Each character sent on `txd_in` (start 0, M-2 payload bits LSB first, stop 1, each bit 16 `smp_en` samples long) is reproduced on `sync_out` with the same payload bits, one bit per `bit_en`.
- R3: Outside bypass, `sync_out` changes only on a clock edge at which `bit_en` is high.
- R4: When the synchronous side is faster, additional mark bits are inserted between characters and no payload bit is lost.
- R5: When the asynchronous side is faster, a stop bit is omitted (the next start bit follows the last payload bit directly). Two omissions are at least 8 characters apart with `ext_rate`=0, and at least 4 characters apart with `ext_rate`=1.
- R6: A character whose M bits are all space is a break. The output then sends exactly 2M+3 space bits, or more when the line stays at space beyond that.
- R7: After a stretched break, at least 2M mark bits are sent before the next character's start bit.
- R8: With `hs_mode`=1 no stop bit is ever omitted, and a break is not stretched to 2M+3 bits.
- R9: With `bypass`=1, `sync_out` equals `txd_in` combinationally.
- R10: A start bit that has returned to mark by its 8th sample is rejected and produces no output character. The next valid character is still received.
- R11: During and after reset, and whenever no character is buffered, `sync_out` is mark (1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Sample enable at 16x the bit rate |
| bit_en | input | 1 | Synchronous bit enable, one pulse per output bit |
| txd_in | input | 1 | Asynchronous start-stop data, 1 = mark |
| len_sel | input | 2 | Character length code |
| ext_rate | input | 1 | 1 = extended tolerance (omission every 4th character allowed) |
| hs_mode | input | 1 | 1 = boosted synchronous clock: no omission, no break stretching |
| bypass | input | 1 | 1 = output follows input directly |
| sync_out | output | 1 | Synchronous data out |

## Verification
A new output bit is registered on the edge where `bit_en` is high. The bench samples it at the next falling edge, half a cycle after that edge. A character enters the buffer at the mid-bit sample of its stop bit. It starts on the first `bit_en` after that, unless it takes the place of an omitted stop bit. The bench therefore does not predict absolute cycles for characters. It decodes the sampled stream bit by bit and compares payloads, omission positions, inserted marks and run lengths with values derived from M. Between bit pulses it checks that the output holds steady. In bypass mode it checks the output one time step after each input change.

// File: rtl/astx_rate_adapter.sv
module astx_rate_adapter #(
  parameter int MAX_LEN = 11,
  parameter int DEPTH   = 2,
  parameter int RUN_W   = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_en,
  input  logic       bit_en,
  input  logic       txd_in,
  input  logic [1:0] len_sel,
  input  logic       ext_rate,
  input  logic       hs_mode,
  input  logic       bypass,
  output logic       sync_out
);
  localparam int BODY_W = MAX_LEN - 2;
  localparam int IDX_W  = $clog2(MAX_LEN + 1);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  localparam logic [1:0] R_IDLE = 2'd0, R_CHAR = 2'd1, R_BRK = 2'd2;
  localparam logic [2:0] T_IDLE = 3'd0, T_BODY = 3'd1, T_STOP = 3'd2,
                         T_BRK  = 3'd3, T_MARK = 3'd4;

  logic [IDX_W-1:0] clen;
  always_comb begin
    case (len_sel)
      2'b10:   clen = IDX_W'(8);
      2'b00:   clen = IDX_W'(9);
      2'b11:   clen = IDX_W'(10);
      default: clen = IDX_W'(11);
    endcase
  end

  logic [RUN_W-1:0] brk_min, mark_end;
  logic [2:0]       del_lim;
  assign brk_min  = hs_mode ? RUN_W'(clen) : RUN_W'(32'(clen) * 2 + 3);
  assign mark_end = RUN_W'(32'(clen) * 2 - 1);
  assign del_lim  = ext_rate ? 3'd3 : 3'd7;

  // receive side
  logic [1:0]        rx_st;
  logic [3:0]        rx_ph;
  logic [IDX_W-1:0]  rx_idx;
  logic [BODY_W-1:0] rx_body;
  logic              rx_zero, brk_on;
  logic              rx_mid, rx_last, push_chr, push_brk, push;

  assign rx_mid   = smp_en && rx_st == R_CHAR && rx_ph == 4'd7;
  assign rx_last  = rx_mid && rx_idx == clen - IDX_W'(1);
  assign push_chr = rx_last && txd_in;
  assign push_brk = rx_last && !txd_in && rx_zero;
  assign push     = push_chr || push_brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st   <= R_IDLE;
      rx_ph   <= '0;
      rx_idx  <= '0;
      rx_body <= '0;
      rx_zero <= 1'b0;
      brk_on  <= 1'b0;
    end else if (smp_en) begin
      case (rx_st)
        R_IDLE: if (!txd_in) begin
          rx_st   <= R_CHAR;
          rx_ph   <= 4'd1;
          rx_idx  <= '0;
          rx_zero <= 1'b1;
        end
        R_CHAR: begin
          rx_ph <= rx_ph + 4'd1;
          if (rx_ph == 4'd7) begin
            if (rx_idx == '0) begin
              if (txd_in) rx_st <= R_IDLE;
              else        rx_idx <= IDX_W'(1);
            end else if (rx_idx == clen - IDX_W'(1)) begin
              if (push_brk) begin
                rx_st  <= R_BRK;
                brk_on <= 1'b1;
              end else begin
                rx_st <= R_IDLE;
              end
            end else begin
              rx_body[rx_idx - IDX_W'(1)] <= txd_in;
              rx_zero <= rx_zero & ~txd_in;
              rx_idx  <= rx_idx + IDX_W'(1);
            end
          end
        end
        R_BRK: begin
          rx_ph <= rx_ph + 4'd1;
          if (rx_ph == 4'd7 && txd_in) begin
            brk_on <= 1'b0;
            rx_st  <= R_IDLE;
          end
        end
        default: rx_st <= R_IDLE;
      endcase
    end
  end

  // character buffer: {is_break, payload}
  logic [BODY_W:0]   mem [DEPTH];
  logic [PTR_W-1:0]  wr_p, rd_p;
  logic [CNT_W-1:0]  fcnt;
  logic [BODY_W:0]   head;
  logic              do_push, pop, can_del;

  assign head    = mem[rd_p];
  assign do_push = push && fcnt != CNT_W'(DEPTH);

  logic [2:0] tx_st;
  logic [2:0] del_cnt;

  assign can_del = !hs_mode && del_cnt >= del_lim && fcnt != '0 && !head[BODY_W];
  assign pop     = bit_en && ((tx_st == T_IDLE && fcnt != '0) || (tx_st == T_STOP && can_del));

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_p] <= {push_brk, rx_body};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p <= '0;
      rd_p <= '0;
      fcnt <= '0;
    end else begin
      if (do_push) wr_p <= (32'(wr_p) == DEPTH - 1) ? '0 : wr_p + PTR_W'(1);
      if (pop)     rd_p <= (32'(rd_p) == DEPTH - 1) ? '0 : rd_p + PTR_W'(1);
      fcnt <= fcnt + CNT_W'(do_push) - CNT_W'(pop);
    end
  end

  // transmit side
  logic [IDX_W-1:0]  tx_idx;
  logic [BODY_W-1:0] tx_body;
  logic [RUN_W-1:0]  run_cnt;
  logic              out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_st   <= T_IDLE;
      tx_idx  <= '0;
      tx_body <= '0;
      run_cnt <= '0;
      del_cnt <= 3'd7;
      out_q   <= 1'b1;
    end else if (bit_en) begin
      case (tx_st)
        T_IDLE: begin
          if (fcnt != '0) begin
            out_q <= 1'b0;
            if (head[BODY_W]) begin
              tx_st   <= T_BRK;
              run_cnt <= RUN_W'(1);
            end else begin
              tx_st   <= T_BODY;
              tx_body <= head[BODY_W-1:0];
              tx_idx  <= '0;
            end
          end else begin
            out_q <= 1'b1;
          end
        end
        T_BODY: begin
          out_q <= tx_body[tx_idx];
          if (tx_idx == clen - IDX_W'(3)) tx_st <= T_STOP;
          else                            tx_idx <= tx_idx + IDX_W'(1);
        end
        T_STOP: begin
          if (can_del) begin
            out_q   <= 1'b0;
            tx_body <= head[BODY_W-1:0];
            tx_idx  <= '0;
            tx_st   <= T_BODY;
            del_cnt <= '0;
          end else begin
            out_q <= 1'b1;
            tx_st <= T_IDLE;
            if (del_cnt != 3'd7) del_cnt <= del_cnt + 3'd1;
          end
        end
        T_BRK: begin
          if (run_cnt >= brk_min && !brk_on) begin
            out_q <= 1'b1;
            if (hs_mode) begin
              tx_st <= T_IDLE;
            end else begin
              tx_st   <= T_MARK;
              run_cnt <= RUN_W'(1);
            end
          end else begin
            out_q <= 1'b0;
            if (run_cnt != '1) run_cnt <= run_cnt + RUN_W'(1);
          end
        end
        T_MARK: begin
          out_q <= 1'b1;
          if (run_cnt >= mark_end) tx_st   <= T_IDLE;
          else                     run_cnt <= run_cnt + RUN_W'(1);
        end
        default: tx_st <= T_IDLE;
      endcase
    end
  end

  assign sync_out = bypass ? txd_in : out_q;

endmodule

// File: rtl/astx_rate_adapter_chk.sv
module astx_rate_adapter_chk #(
  parameter int DEPTH = 2,
  parameter int IDX_W = 4,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             bypass,
  input logic             hs_mode,
  input logic             ext_rate,
  input logic [IDX_W-1:0] clen,
  input logic             sync_out,
  input logic [2:0]       tx_st,
  input logic [CNT_W-1:0] fcnt
);
  localparam logic [2:0] T_IDLE = 3'd0, T_BODY = 3'd1, T_STOP = 3'd2,
                         T_BRK  = 3'd3, T_MARK = 3'd4;

  logic [2:0] prev_st;
  logic       bit_d, after_brk;
  logic [5:0] zrun, orun;
  logic [3:0] since_del;
  logic       del_ev, stop_ev, brk_exit;

  assign del_ev   = prev_st == T_STOP && tx_st == T_BODY;
  assign stop_ev  = prev_st == T_STOP && tx_st == T_IDLE;
  assign brk_exit = prev_st == T_BRK && tx_st == T_MARK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_st   <= T_IDLE;
      bit_d     <= 1'b0;
      zrun      <= '0;
      orun      <= '0;
      after_brk <= 1'b0;
      since_del <= 4'd15;
    end else begin
      prev_st <= tx_st;
      bit_d   <= bit_en;
      if (bit_d) begin
        if (sync_out) begin
          zrun <= '0;
          if (orun != '1) orun <= orun + 6'd1;
        end else begin
          orun <= '0;
          if (zrun != '1) zrun <= zrun + 6'd1;
        end
      end
      if (brk_exit) after_brk <= 1'b1;
      else if (bit_d && !sync_out) after_brk <= 1'b0;
      if (del_ev) since_del <= '0;
      else if (stop_ev && since_del != 4'd15) since_del <= since_del + 4'd1;
    end
  end

  assert_hold_between_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && $past(!bypass) && !$past(bit_en)) |-> $stable(sync_out));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fcnt) <= DEPTH);

  assert_break_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_exit && !bypass) |-> 32'(zrun) >= 32'(clen) * 2 + 3);

  assert_guard_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (after_brk && bit_d && !sync_out && !bypass) |-> 32'(orun) >= 32'(clen) * 2);

  assert_no_delete_hs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    del_ev |-> !$past(hs_mode));

  assert_delete_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    del_ev |-> since_del >= (ext_rate ? 4'd3 : 4'd7));

endmodule

bind astx_rate_adapter astx_rate_adapter_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bypass(bypass), .hs_mode(hs_mode),
  .ext_rate(ext_rate), .clen(clen), .sync_out(sync_out), .tx_st(tx_st), .fcnt(fcnt)
);

// File: tb/test_astx_rate_adapter.sv
module test_astx_rate_adapter;
  logic clk = 1'b0;
  logic rst_n, smp_en, bit_en, txd_in, ext_rate, hs_mode, bypass;
  logic [1:0] len_sel;
  logic sync_out;

  always #2 clk = ~clk;

  astx_rate_adapter i_astx_rate_adapter (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .bit_en(bit_en), .txd_in(txd_in),
    .len_sel(len_sel), .ext_rate(ext_rate), .hs_mode(hs_mode), .bypass(bypass),
    .sync_out(sync_out)
  );

  int nchk = 0, nfail = 0;
  int base_per = 16, slip = 0, bitnum = 0;
  int m_b = 8;
  int mon = 0, run_mode = 0, chg_bad = 0;
  logic last_s = 1'b1;
  int ps = 0, pidx = 0, got_n = 0, dels = 0, last_del = -1, min_gap = 1000;
  int ins_ev = 0, idle_ones = 0;
  logic [8:0] pbody;
  logic [8:0] got [0:127];
  logic [8:0] sent [0:127];
  int nruns = 0, cur_v = 0, cur_l = 0;
  int run_v [0:15];
  int run_l [0:15];

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic store_run();
    if (cur_l > 0 && nruns < 16) begin
      run_v[nruns] = cur_v;
      run_l[nruns] = cur_l;
      nruns++;
    end
    cur_l = 0;
  endtask

  task automatic sample_bit(input logic b);
    if (mon == 0) return;
    if (run_mode != 0) begin
      if (cur_l == 0 && nruns == 0 && b == 1'b1) return;
      if (cur_l == 0) begin cur_v = int'(b); cur_l = 1; end
      else if (int'(b) == cur_v) cur_l++;
      else begin store_run(); cur_v = int'(b); cur_l = 1; end
      return;
    end
    case (ps)
      0: if (b == 1'b0) begin
           if (got_n > 0 && idle_ones > 0) ins_ev++;
           ps = 1; pidx = 0; pbody = '0;
         end else idle_ones++;
      1: begin
           pbody[pidx] = b;
           pidx++;
           if (pidx == m_b - 2) ps = 2;
         end
      default: begin
           if (got_n < 128) got[got_n] = pbody;
           got_n++;
           if (b == 1'b1) begin
             ps = 0; idle_ones = 0;
           end else begin
             if (last_del >= 0 && got_n - 1 - last_del < min_gap) min_gap = got_n - 1 - last_del;
             last_del = got_n - 1;
             dels++;
             ps = 1; pidx = 0; pbody = '0;
           end
         end
    endcase
  endtask

  initial begin
    bit_en = 1'b0;
    forever begin
      int per;
      per = base_per + ((slip != 0 && bitnum % slip == 0) ? 1 : 0);
      bitnum++;
      for (int k = 0; k < per - 1; k++) begin
        @(negedge clk);
        if (rst_n === 1'b1 && bypass === 1'b0 && sync_out !== last_s) chg_bad++;
      end
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      last_s = sync_out;
      sample_bit(sync_out);
    end
  end

  task automatic send_bits(input logic v, input int n);
    txd_in = v;
    repeat (16 * n) @(negedge clk);
  endtask

  task automatic send_char(input logic [8:0] body, input int m);
    send_bits(1'b0, 1);
    for (int i = 0; i < m - 2; i++) send_bits(body[i], 1);
    send_bits(1'b1, 1);
  endtask

  task automatic start_mon(input int rm);
    mon = 0; run_mode = rm;
    ps = 0; got_n = 0; dels = 0; last_del = -1; min_gap = 1000;
    ins_ev = 0; idle_ones = 0; nruns = 0; cur_l = 0;
    mon = 1;
  endtask

  task automatic stream(input int n, input int mul, input int add, input string req);
    logic [8:0] mask;
    mask = 9'((1 << (m_b - 2)) - 1);
    start_mon(0);
    for (int i = 0; i < n; i++) begin
      sent[i] = 9'((i * mul + add)) & mask;
      send_char(sent[i], m_b);
    end
    send_bits(1'b1, 6 * m_b);
    check(got_n == n, {req, " character count"}, got_n, n);
    for (int i = 0; i < n && i < got_n; i++)
      check(got[i] == sent[i], {req, " payload"}, int'(got[i]), int'(sent[i]));
  endtask

  initial begin
    int wd = 0;
    while (wd < 190000) begin @(posedge clk); wd++; end
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=0", wd);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    logic [1:0] codes [4];
    codes[0] = 2'b10; codes[1] = 2'b00; codes[2] = 2'b11; codes[3] = 2'b01;
    rst_n = 1'b0; smp_en = 1'b0; txd_in = 1'b1; len_sel = 2'b10;
    ext_rate = 1'b0; hs_mode = 1'b0; bypass = 1'b0;
    repeat (5) @(negedge clk);
    check(sync_out == 1'b1, "R11 output during reset", int'(sync_out), 1);
    rst_n = 1'b1; smp_en = 1'b1;
    repeat (60) @(negedge clk);
    check(sync_out == 1'b1, "R11 idle after reset", int'(sync_out), 1);

    // R1 R2: every length code, payload sweep, matched rates
    for (int c = 0; c < 4; c++) begin
      len_sel = codes[c]; m_b = 8 + c;
      stream((c == 0) ? 64 : 24, (c == 0) ? 1 : 37, (c == 0) ? 0 : 5, "R1 R2 length");
    end
    check(chg_bad == 0, "R3 output moved without bit_en", chg_bad, 0);

    // R4: faster synchronous side
    len_sel = 2'b11; m_b = 10; base_per = 15;
    stream(12, 29, 3, "R4");
    check(ins_ev >= 1, "R4 inserted marks", ins_ev, 1);
    check(dels == 0, "R4 no omission", dels, 0);

    // R5 basic tolerance
    len_sel = 2'b10; m_b = 8; base_per = 16; slip = 10;
    stream(48, 23, 7, "R5 basic");
    check(dels >= 1, "R5 basic omission happened", dels, 1);
    check(min_gap >= 8, "R5 basic spacing", min_gap, 8);

    // R5 extended tolerance
    ext_rate = 1'b1; slip = 4;
    stream(48, 23, 7, "R5 ext");
    check(dels >= 2, "R5 ext omissions happened", dels, 2);
    check(min_gap >= 4, "R5 ext spacing", min_gap, 4);

    // R8 boosted clock, no omission
    ext_rate = 1'b0; hs_mode = 1'b1;
    stream(10, 11, 1, "R8");
    check(dels == 0, "R8 no omission", dels, 0);
    hs_mode = 1'b0; slip = 0;
    send_bits(1'b1, 20);

    // R6 R7 short break followed by a character
    start_mon(1);
    send_bits(1'b0, m_b + 2);
    send_bits(1'b1, 1);
    send_char(9'h03F, m_b);
    send_bits(1'b1, 6 * m_b);
    store_run();
    check(run_v[0] == 0 && run_l[0] == 2 * m_b + 3, "R6 stretched break length", run_l[0], 2 * m_b + 3);
    check(run_l[1] >= 2 * m_b, "R7 guard marks", run_l[1], 2 * m_b);
    check(nruns >= 3 && run_l[2] == 1, "R7 character after guard", run_l[2], 1);

    // R6 long break
    start_mon(1);
    send_bits(1'b0, 4 * m_b);
    send_bits(1'b1, 6 * m_b);
    store_run();
    check(run_l[0] > 2 * m_b + 3, "R6 long break passed", run_l[0], 2 * m_b + 4);

    // R8 break unchanged
    hs_mode = 1'b1;
    start_mon(1);
    send_bits(1'b0, m_b + 2);
    send_bits(1'b1, 6 * m_b);
    store_run();
    check(run_l[0] >= m_b && run_l[0] < 2 * m_b + 3, "R8 break not stretched", run_l[0], m_b);
    hs_mode = 1'b0;

    // R10 glitch
    start_mon(0);
    txd_in = 1'b0;
    repeat (5) @(negedge clk);
    send_bits(1'b1, 3 * m_b);
    check(got_n == 0 && ps == 0, "R10 glitch ignored", got_n, 0);
    check(sync_out == 1'b1, "R11 idle after glitch", int'(sync_out), 1);
    stream(1, 1, 42, "R10 recovery");
    check(chg_bad == 0, "R3 output moved without bit_en", chg_bad, 0);

    // R9 bypass
    bypass = 1'b1;
    for (int i = 0; i < 8; i++) begin
      txd_in = 1'(i % 3 == 1);
      #1;
      check(sync_out == txd_in, "R9 bypass follows input", int'(sync_out), int'(txd_in));
      @(negedge clk);
    end
    txd_in = 1'b1;
    @(negedge clk);
    bypass = 1'b0;
    #1;
    check(sync_out == 1'b1, "R11 idle after bypass", int'(sync_out), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule